// File: doc/BRIEF.md
# Keyed-write watchdog timer

This block is a watchdog and interval timer. An 8-bit up-counter advances once per prescaler period. The prescaler divides the input clock by 32 times a power of two, and a 3-bit field in the control/status byte picks that power. When the counter rolls over from 0xFF to 0x00, the block sets a sticky overflow flag. It then does one of two things. In watchdog mode it pulses a reset request for one cycle. In interval mode it holds a level interrupt for as long as the flag stays set.

Software reaches the block through a small register bus. A write carries 16 bits and selects one of two registers. The low byte is the payload and the high byte must equal that register's own key, or the write is discarded. A read returns one byte, registered, one cycle after the select is presented. Software keeps the watchdog from expiring by reloading the counter with a keyed write before it wraps.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0x00, the control/status byte reads 0x00 (divide-by-32, timer stopped, interval mode, flag clear), and both wdt_rst_req and wdt_irq are low.
- R2: A write with wr_sel=0 whose upper byte is 0x5A loads wr_data[7:0] into the counter. A read with rd_sel=0 returns the counter value one cycle later.
- R3: A write with wr_sel=1 whose upper byte is 0xA5 updates the control/status byte. The layout is bit 7 enable, bit 6 mode, bit 4 overflow flag and bits 2:0 clock select. Bits 5 and 3 always read 0. A read with rd_sel=1 returns this byte.
- R4: A write whose upper byte is not the key of the selected register changes neither register.
- R5: While enable (bit 7) is 0, the counter holds its value.
- R6: While enabled with clock-select code c, the counter advances by one every 32·2^c input clocks.
- R7: A keyed control/status write that changes the clock-select code restarts the prescaler period, so the next increment comes one full new period after that write.
- R8: The wrap from 0xFF to 0x00 sets the flag (bit 4). The flag stays set until a keyed control/status write puts 0 in bit 4. Writing 1 in bit 4 never sets the flag.
- R9: In watchdog mode (bit 6 = 1), every wrap produces exactly one cycle of wdt_rst_req, starting the cycle after the wrapping edge.
- R10: wdt_irq is high exactly while the flag is set and the mode bit is 0.
- R11: A keyed counter write in the same cycle as an increment wins: the counter takes the written value and no wrap is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control/status |
| wr_data | input | 16 | Key byte in [15:8], payload in [7:0] |
| rd_sel | input | 1 | Read source: 0 counter, 1 control/status |
| rd_data | output | 8 | Registered read byte |
| wdt_rst_req | output | 1 | One-cycle reset request on overflow in watchdog mode |
| wdt_irq | output | 1 | Level interrupt in interval mode |

## Verification
The assertions take for granted that wr_en, wr_sel and wr_data are stable during each clock cycle and are defined once reset is released. The one-cycle pulse check also relies on the shortest prescaler period of 32 clocks, so that two wraps can never fall on adjacent cycles. The stimulus drives every input on the falling edge and makes at most one write per cycle. It deliberately sends wrong keys, including one register's key aimed at the other register. It also times a counter write to land exactly on an increment edge.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam logic [7:0] KEY_CTRL  = 8'hA5;
  localparam int CKS_W     = 3;
  localparam int BIT_EN    = 7;
  localparam int BIT_MODE  = 6;
  localparam int BIT_FLAG  = 4;

  typedef struct packed {
    logic             en;
    logic             wd_mode;
    logic             flag;
    logic [CKS_W-1:0] cks;
  } ctrl_t;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int CKS_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int MAXSH = (1 << CKS_W) - 1;
  localparam int PRE_W = BASE_LOG2 + MAXSH;
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] term;

  // terminal count = divide ratio - 1, a right-shifted run of ones
  assign term = ONES >> (CKS_W'(MAXSH) - cks);
  assign tick = run && (phase == term);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) phase <= '0;
    else if (tick)              phase <= '0;
    else                        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = tick && !load && (&count);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ok,
  input  logic [7:0] wbyte,
  input  logic       wrap,
  output ctrl_t      ctrl,
  output logic       cks_change,
  output logic [7:0] csr_byte,
  output logic       rst_req,
  output logic       irq
);
  ctrl_t nxt;

  assign cks_change = wr_ok && (wbyte[CKS_W-1:0] != ctrl.cks);

  always_comb begin
    nxt = ctrl;
    if (wr_ok) begin
      nxt.en      = wbyte[BIT_EN];
      nxt.wd_mode = wbyte[BIT_MODE];
      nxt.cks     = wbyte[CKS_W-1:0];
      nxt.flag    = ctrl.flag && wbyte[BIT_FLAG];
    end
    if (wrap) nxt.flag = 1'b1;
  end

  always_comb begin
    csr_byte = '0;
    csr_byte[BIT_EN]      = ctrl.en;
    csr_byte[BIT_MODE]    = ctrl.wd_mode;
    csr_byte[BIT_FLAG]    = ctrl.flag;
    csr_byte[CKS_W-1:0]   = ctrl.cks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ctrl    <= nxt;
      rst_req <= wrap && ctrl.wd_mode;
      irq     <= nxt.flag && !nxt.wd_mode;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [7:0]  rd_data,
  output logic        wdt_rst_req,
  output logic        wdt_irq
);
  localparam int CNT_W = 8;

  logic       cnt_wr, ctl_wr, tick, wrap, cks_change;
  logic [CNT_W-1:0] count;
  logic [7:0] csr_byte;
  ctrl_t      ctrl;

  assign cnt_wr = wr_en && !wr_sel && (wr_data[15:8] == KEY_COUNT);
  assign ctl_wr = wr_en &&  wr_sel && (wr_data[15:8] == KEY_CTRL);

  kwdt_prescaler #(.BASE_LOG2(BASE_LOG2), .CKS_W(CKS_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl.en), .restart(cks_change),
    .cks(ctrl.cks), .tick(tick)
  );

  kwdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(wr_data[CNT_W-1:0]),
    .tick(tick), .count(count), .wrap(wrap)
  );

  kwdt_ctrl u_ctl (
    .clk(clk), .rst(rst), .wr_ok(ctl_wr), .wbyte(wr_data[7:0]), .wrap(wrap),
    .ctrl(ctrl), .cks_change(cks_change), .csr_byte(csr_byte),
    .rst_req(wdt_rst_req), .irq(wdt_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? csr_byte : count;
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] wr_data,
  input logic [7:0]  count,
  input logic        en,
  input logic        wd_mode,
  input logic        flag,
  input logic [2:0]  cks,
  input logic        wdt_rst_req,
  input logic        wdt_irq
);
  logic cnt_key_ok, ctl_key_ok, ctl_bad_key;
  assign cnt_key_ok  = wr_en && !wr_sel && (wr_data[15:8] == 8'h5A);
  assign ctl_key_ok  = wr_en &&  wr_sel && (wr_data[15:8] == 8'hA5);
  assign ctl_bad_key = wr_en &&  wr_sel && (wr_data[15:8] != 8'hA5);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_key_ok) |=> $stable(count));

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_key_ok |=> (count == $past(count) || count == $past(count) + 8'd1));

  a_r4_bad_key: assert property (@(posedge clk) disable iff (rst)
    ctl_bad_key |=> ($stable(en) && $stable(wd_mode) && $stable(cks)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(ctl_key_ok && !wr_data[4])) |=> flag);

  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |=> !wdt_rst_req);

  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> flag);

  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |-> (flag && !wd_mode));
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .count(count), .en(ctrl.en), .wd_mode(ctrl.wd_mode), .flag(ctrl.flag),
  .cks(ctrl.cks), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        wdt_rst_req, wdt_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_pc, m_cks, m_rd;
  bit m_en, m_mode, m_flag, m_rst, m_irq;

  keyed_wdt dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int csr_val();
    return (m_en ? 128 : 0) + (m_mode ? 64 : 0) + (m_flag ? 16 : 0) + m_cks;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_cnt = 0; m_pc = 0; m_cks = 0; m_rd = 0;
      m_en = 0; m_mode = 0; m_flag = 0; m_rst = 0; m_irq = 0;
    end else begin
      bit tick, wrap, cw, sw, chg;
      int div;
      div  = 32 * (1 << m_cks);
      tick = m_en && (m_pc == div - 1);
      cw   = wr_en && !wr_sel && (wr_data[15:8] == 8'h5A);
      sw   = wr_en &&  wr_sel && (wr_data[15:8] == 8'hA5);
      chg  = sw && (int'(wr_data[2:0]) != m_cks);
      wrap = tick && !cw && (m_cnt == 255);
      m_rd  = rd_sel ? csr_val() : m_cnt;
      m_rst = wrap && m_mode;
      if (!m_en || chg || tick) m_pc = 0; else m_pc = m_pc + 1;
      if (cw) m_cnt = int'(wr_data[7:0]);
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (sw) begin
        m_en = wr_data[7]; m_mode = wr_data[6]; m_cks = int'(wr_data[2:0]);
        m_flag = m_flag && wr_data[4];
      end
      if (wrap) m_flag = 1;
      m_irq = m_flag && !m_mode;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      check(cur_req, "rd_data(model)", int'(rd_data), m_rd);
      check(cur_req, "wdt_rst_req(model)", int'(wdt_rst_req), int'(m_rst));
      check(cur_req, "wdt_irq(model)", int'(wdt_irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL timeout (all requirements) actual=%0d expected<%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_expect(bit sel, string req, int exp);
    rd_sel = sel;
    @(negedge clk);
    check(req, sel ? "csr read" : "count read", int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check("R1", "wdt_rst_req", int'(wdt_rst_req), 0);
    check("R1", "wdt_irq", int'(wdt_irq), 0);
    rd_expect(0, "R1", 8'h00);
    rd_expect(1, "R1", 8'h00);
    // R2 keyed counter load
    cur_req = "R2";
    wr(0, 16'h5A3C);
    rd_expect(0, "R2", 8'h3C);
    // R4 wrong keys
    cur_req = "R4";
    wr(0, 16'h5B77);
    rd_expect(0, "R4", 8'h3C);
    wr(1, 16'h5A87);
    rd_expect(1, "R4", 8'h00);
    wr(0, 16'hA511);
    rd_expect(0, "R4", 8'h3C);
    // R3 csr write, reserved bits read 0, flag cannot be set by writing 1
    cur_req = "R3";
    wr(1, 16'hA53A);
    rd_expect(1, "R3", 8'h02);
    // R5 held while disabled
    cur_req = "R5";
    idle(300);
    rd_expect(0, "R5", 8'h3C);
    // R6 rates at several codes, then code 7 through a wrap
    cur_req = "R6";
    rd_sel = 1'b0;
    wr(0, 16'h5A00);
    for (int c = 0; c < 3; c++) begin
      wr(1, 16'hA580 | 16'(c));
      idle(4 * (32 << c));
    end
    wr(1, 16'hA500);
    wr(0, 16'h5AFE);
    wr(1, 16'hA587);
    idle(2 * 4096 + 40);
    rd_expect(1, "R8", 8'h97);
    // R10 level interrupt in interval mode
    cur_req = "R10";
    check("R10", "wdt_irq set", int'(wdt_irq), 1);
    // R8 flag sticky, writing 1 keeps it, writing 0 clears
    cur_req = "R8";
    wr(1, 16'hA597);
    rd_expect(1, "R8", 8'h97);
    wr(1, 16'hA507);
    rd_expect(1, "R8", 8'h07);
    check("R10", "wdt_irq cleared", int'(wdt_irq), 0);
    // R7 clock-select change restarts prescaler
    cur_req = "R7";
    wr(0, 16'h5A00);
    wr(1, 16'hA583);
    idle(100);
    wr(1, 16'hA580);
    idle(100);
    wr(1, 16'hA500);
    rd_expect(0, "R7", 8'h03);
    // R9 watchdog mode pulse
    cur_req = "R9";
    wr(0, 16'h5AFF);
    wr(1, 16'hA5C0);
    begin
      int pulses = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (wdt_rst_req) pulses++;
      end
      check("R9", "reset pulse count", pulses, 1);
    end
    check("R10", "no irq in watchdog mode", int'(wdt_irq), 0);
    wr(1, 16'hA540);
    // R11 load collides with increment
    cur_req = "R11";
    rd_sel = 1'b0;
    wr(0, 16'h5A10);
    wr(1, 16'hA580);
    idle(31);
    wr(0, 16'h5A40);
    rd_expect(0, "R11", 8'h40);
    wr(1, 16'hA500);
    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule